// File: doc/BRIEF.md
# Three-Level Idle Power Controller

This block sits beside a processor core and turns a decoded idle request into clock-enable levels for three domains: the CPU, the on-chip peripherals and the PLL. Each request carries a depth of 1, 2 or 3. A deeper level shuts down a larger set of domains. Depth 1 stops only the CPU. Depth 2 also stops the peripherals. Depth 3 also stops the PLL.

A wake event brings the domains back in a safe order. The wake event is an enabled interrupt, on the `wake` input, or a reset. After depth 2 the peripherals return one cycle ahead of the CPU. After depth 3 the PLL is re-enabled first. The CPU and peripherals then stay off until the lock input has been high for `LOCK_CYCLES` consecutive cycles. A 3-bit mode output reports where the sequence stands. The gating cells and the PLL itself are outside this block.

The controller is a Moore machine with six states:

| State | Meaning |
|---|---|
| `S_RUN` | Running. |
| `S_IDLE1` | Idle at depth 1. |
| `S_IDLE2` | Idle at depth 2. |
| `S_IDLE3` | Idle at depth 3. |
| `S_LOCK` | Waiting for PLL lock. |
| `S_WAKE2` | Peripherals are back and the CPU is still off. |

Its transitions are:

| From | Condition | To |
|---|---|---|
| `S_RUN` | Request with depth n, where n is 1, 2 or 3 | `S_IDLEn` |
| `S_IDLE1` | `wake` | `S_RUN` |
| `S_IDLE2` | `wake` | `S_WAKE2` |
| `S_WAKE2` | Unconditional | `S_RUN` |
| `S_IDLE3` | `wake` | `S_LOCK` |
| `S_LOCK` | Lock seen for the required count | `S_RUN` |
| Any state | Reset | `S_RUN` |

Top module: `idle_pwr_ctrl`

## Requirements
- R1: During and after reset, `cpu_clk_en`, `per_clk_en` and `pll_en` are all 1 and `mode` is 0 (running).
- R2: In the running state, a request with `idle_lvl`=1 gives `cpu_clk_en`=0, `per_clk_en`=1, `pll_en`=1 and `mode`=1 after the next clock edge.
- R3: In the running state, a request with `idle_lvl`=2 gives `cpu_clk_en`=0, `per_clk_en`=0, `pll_en`=1 and `mode`=2 after the next edge.
- R4: In the running state, a request with `idle_lvl`=3 gives all three enables at 0 and `mode`=3 after the next edge.
- R5: A request with `idle_lvl`=0 has no effect. A `wake` while running also has no effect.
- R6: `wake` at depth 1 returns to running, with all enables at 1 and `mode`=0, after the next edge.
- R7: `wake` at depth 2 raises `per_clk_en` after the next edge while `cpu_clk_en` stays 0 and `mode` stays 2. `cpu_clk_en` rises one edge later and `mode` becomes 0.
- R8: `wake` at depth 3 sets `pll_en`=1, `cpu_clk_en`=0, `per_clk_en`=0 and `mode`=4 after the next edge.
- R9: In mode 4, the CPU and peripheral enables both return, with `mode`=0, at the edge that samples `pll_lock` high for the `LOCK_CYCLES`-th consecutive time. A low sample restarts the count.
- R10: Idle requests made while not running are ignored.
- R11: Reset in the middle of a wake sequence at once forces all enables to 1 and `mode` to 0.
- R12: `cpu_clk_en`=1 always implies `per_clk_en`=1, and `per_clk_en`=1 always implies `pll_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock. |
| rst_n | input | 1 | Asynchronous active-low reset. It also acts as a wake event. |
| idle_req | input | 1 | One-cycle strobe of a decoded idle request. |
| idle_lvl | input | 2 | Requested depth, 1 to 3. The value 0 is void. |
| wake | input | 1 | Enabled interrupt asking to wake. |
| pll_lock | input | 1 | Lock indication from the PLL. |
| cpu_clk_en | output | 1 | Clock enable for the CPU domain. |
| per_clk_en | output | 1 | Clock enable for the peripheral domain. |
| pll_en | output | 1 | Run enable for the PLL. |
| mode | output | 3 | Current mode: 0 running, 1 to 3 idle depth, 4 waiting for lock. |

## Verification
The assertions take four things for granted about the inputs. `idle_lvl` is meaningful only in a cycle where `idle_req` is high. `wake` comes from an interrupt that is already enabled. `pll_lock` matters only while the controller waits in mode 4. Inputs change away from the rising edge. The stimulus keeps to this by driving every input on the falling edge and holding `pll_lock` low until a depth-3 wake has been taken. It also covers a lock drop part-way through the count, void and late requests, and a reset in the middle of a sequence.

// File: rtl/idle_pwr_pkg.sv
package idle_pwr_pkg;

    typedef enum logic [2:0] {
        S_RUN   = 3'd0,
        S_IDLE1 = 3'd1,
        S_IDLE2 = 3'd2,
        S_IDLE3 = 3'd3,
        S_LOCK  = 3'd4,
        S_WAKE2 = 3'd5
    } pwr_state_e;

    localparam logic [2:0] MODE_RUN  = 3'd0;
    localparam logic [2:0] MODE_LOCK = 3'd4;

    typedef struct packed {
        logic cpu;
        logic per;
        logic pll;
    } dom_en_t;

endpackage

// File: rtl/idle_req_decode.sv
module idle_req_decode
    import idle_pwr_pkg::*;
(
    input  logic       req,
    input  logic [1:0] lvl,
    output logic       valid,
    output pwr_state_e target
);
    // Maps a request depth to its idle state. Depth 0 is void.
    always_comb begin
        valid  = req;
        target = S_RUN;
        unique case (lvl)
            2'd1:    target = S_IDLE1;
            2'd2:    target = S_IDLE2;
            2'd3:    target = S_IDLE3;
            default: valid  = 1'b0;
        endcase
    end
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int LOCK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic lock,
    output logic done
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Counts consecutive high samples of lock while armed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!arm || !lock || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = arm && lock && (cnt == LAST);

    // R9: the count never passes its limit.
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/dom_enable_map.sv
module dom_enable_map
    import idle_pwr_pkg::*;
(
    input  pwr_state_e st,
    output dom_en_t    en,
    output logic [2:0] mode
);
    always_comb begin
        en   = '{cpu: 1'b1, per: 1'b1, pll: 1'b1};
        mode = MODE_RUN;
        unique case (st)
            S_RUN: begin
                en   = '{cpu: 1'b1, per: 1'b1, pll: 1'b1};
                mode = MODE_RUN;
            end
            S_IDLE1: begin
                en   = '{cpu: 1'b0, per: 1'b1, pll: 1'b1};
                mode = 3'd1;
            end
            S_IDLE2: begin
                en   = '{cpu: 1'b0, per: 1'b0, pll: 1'b1};
                mode = 3'd2;
            end
            S_IDLE3: begin
                en   = '{cpu: 1'b0, per: 1'b0, pll: 1'b0};
                mode = 3'd3;
            end
            S_LOCK: begin
                en   = '{cpu: 1'b0, per: 1'b0, pll: 1'b1};
                mode = MODE_LOCK;
            end
            S_WAKE2: begin
                en   = '{cpu: 1'b0, per: 1'b1, pll: 1'b1};
                mode = 3'd2;
            end
            default: begin
                en   = '{cpu: 1'b1, per: 1'b1, pll: 1'b1};
                mode = MODE_RUN;
            end
        endcase
    end
endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl
    import idle_pwr_pkg::*;
#(
    parameter int LOCK_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_req,
    input  logic [1:0] idle_lvl,
    input  logic       wake,
    input  logic       pll_lock,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       pll_en,
    output logic [2:0] mode
);
    pwr_state_e cur, nxt;
    pwr_state_e req_target;
    logic       req_ok;
    logic       lock_done;
    dom_en_t    en;

    idle_req_decode u_dec (
        .req    (idle_req),
        .lvl    (idle_lvl),
        .valid  (req_ok),
        .target (req_target)
    );

    pll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (cur == S_LOCK),
        .lock  (pll_lock),
        .done  (lock_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= S_RUN;
        else        cur <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = cur;
        unique case (cur)
            S_RUN:   if (req_ok) nxt = req_target;
            S_IDLE1: if (wake) nxt = S_RUN;
            S_IDLE2: if (wake) nxt = S_WAKE2;
            S_WAKE2: nxt = S_RUN;
            S_IDLE3: if (wake) nxt = S_LOCK;
            S_LOCK:  if (lock_done) nxt = S_RUN;
            default: nxt = S_RUN;
        endcase
    end

    // Outputs
    dom_enable_map u_map (
        .st   (cur),
        .en   (en),
        .mode (mode)
    );

    assign cpu_clk_en = en.cpu;
    assign per_clk_en = en.per;
    assign pll_en     = en.pll;

    a_r12_nesting: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en || per_clk_en) && (!per_clk_en || pll_en));
    a_r2_enter_lvl1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == S_RUN && idle_req && idle_lvl == 2'd1) |=> (mode == 3'd1 && per_clk_en && !cpu_clk_en));
    a_r3_enter_lvl2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == S_RUN && idle_req && idle_lvl == 2'd2) |=> (mode == 3'd2 && pll_en && !per_clk_en));
    a_r4_enter_lvl3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == S_RUN && idle_req && idle_lvl == 2'd3) |=> (mode == 3'd3 && !pll_en));
    a_r6_wake_lvl1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == S_IDLE1 && wake) |=> (mode == MODE_RUN && cpu_clk_en));
    a_r7_wake_order: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == S_IDLE2 && wake) |=> (per_clk_en && !cpu_clk_en) ##1 cpu_clk_en);
    a_r8_wake_lvl3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == S_IDLE3 && wake) |=> (pll_en && !per_clk_en && mode == MODE_LOCK));
    a_r9_need_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == S_LOCK && !pll_lock) |=> !cpu_clk_en);
    a_r10_hold_idle1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == S_IDLE1 && !wake) |=> (mode == 3'd1));
endmodule

// File: tb/test_idle_pwr_ctrl.sv
module test_idle_pwr_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idle_req = 1'b0;
    logic [1:0] idle_lvl = 2'd0;
    logic       wake = 1'b0;
    logic       pll_lock = 1'b0;
    logic       cpu_clk_en, per_clk_en, pll_en;
    logic [2:0] mode;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic       cpu;
        logic       per;
        logic       pll;
        logic [2:0] md;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    idle_pwr_ctrl #(.LOCK_CYCLES(16)) i_idle_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_lvl(idle_lvl),
        .wake(wake), .pll_lock(pll_lock), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .pll_en(pll_en), .mode(mode)
    );

    task automatic compare(input exp_t e);
        checks++;
        if ({cpu_clk_en, per_clk_en, pll_en, mode} !== {e.cpu, e.per, e.pll, e.md}) begin
            failures++;
            $display("FAIL %s: got cpu=%b per=%b pll=%b mode=%0d, exp cpu=%b per=%b pll=%b mode=%0d",
                     e.tag, cpu_clk_en, per_clk_en, pll_en, mode, e.cpu, e.per, e.pll, e.md);
        end
    endtask

    // Monitor: pop and compare on falling edges.
    always @(negedge clk) begin
        if (sb.size() > 0) compare(sb.pop_front());
    end

    // Driver: apply inputs for one edge and queue the result expected after it.
    task automatic step(input logic rq, input logic [1:0] lv, input logic wk, input logic lk,
                        input logic c, input logic p, input logic l, input logic [2:0] m,
                        input string tag);
        exp_t e;
        @(negedge clk);
        idle_req = rq; idle_lvl = lv; wake = wk; pll_lock = lk;
        @(posedge clk);
        e.cpu = c; e.per = p; e.pll = l; e.md = m; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        exp_t e;
        // R1: state during reset
        #3;
        e.cpu = 1; e.per = 1; e.pll = 1; e.md = 0; e.tag = "R1";
        compare(e);
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 0, 1, 1, 1, 0, "R1");
        // R5: void depth and wake while running
        step(1, 0, 0, 0, 1, 1, 1, 0, "R5");
        step(0, 0, 1, 0, 1, 1, 1, 0, "R5");
        // R2, R10, R6
        step(1, 1, 0, 0, 0, 1, 1, 1, "R2");
        step(1, 3, 0, 0, 0, 1, 1, 1, "R10");
        step(0, 0, 1, 0, 1, 1, 1, 0, "R6");
        // R3, R10, R7
        step(1, 2, 0, 0, 0, 0, 1, 2, "R3");
        step(1, 1, 0, 0, 0, 0, 1, 2, "R10");
        step(0, 0, 1, 0, 0, 1, 1, 2, "R7");
        step(0, 0, 0, 0, 1, 1, 1, 0, "R7");
        // R4, R8, R9 with a lock drop
        step(1, 3, 0, 0, 0, 0, 0, 3, "R4");
        step(0, 0, 0, 0, 0, 0, 0, 3, "R4");
        step(0, 0, 1, 0, 0, 0, 1, 4, "R8");
        step(1, 1, 0, 0, 0, 0, 1, 4, "R10");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0, 0, 1, 4, "R9");
        step(0, 0, 0, 0, 0, 0, 1, 4, "R9");
        for (int i = 0; i < 15; i++) step(0, 0, 0, 1, 0, 0, 1, 4, "R9");
        step(0, 0, 0, 1, 1, 1, 1, 0, "R9");
        step(0, 0, 0, 0, 1, 1, 1, 0, "R12");
        // R11: reset in the middle of a lock wait
        step(1, 3, 0, 0, 0, 0, 0, 3, "R11");
        step(0, 0, 1, 0, 0, 0, 1, 4, "R11");
        step(0, 0, 0, 1, 0, 0, 1, 4, "R11");
        @(negedge clk);
        pll_lock = 1'b0;
        rst_n = 1'b0;
        #1;
        e.cpu = 1; e.per = 1; e.pll = 1; e.md = 0; e.tag = "R11";
        compare(e);
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 0, 1, 1, 1, 0, "R11");
        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule